// File: doc/BRIEF.md
# Paired-Byte Palette Memory Writer

This block is the CPU-side write port into a 256-entry color palette whose entries are 15 bits wide. Software sends each color as two byte writes to a single data port. The first byte is parked in a holding register. The second byte completes the entry: its low seven bits become the upper part of the color, the parked byte becomes the lower eight bits, and its top bit is discarded. After that completing write, the entry pointer steps to the next entry, so a whole palette can be streamed with no further address writes.

A separate address port loads the entry pointer and forces the byte sequence back to its first step. Each time an entry is completed, the block presents the red, green and blue fields of that entry on registered outputs. A one-cycle changed strobe marks the completions that altered the stored color. A renderer reads the palette through its own synchronous port, which is independent of the CPU write path.

Top module: `pal_pair_writer`

## Requirements
- R1: After reset the entry pointer is 0, the byte sequence is at its first step, every palette entry reads 0, and chg_o, red_o, grn_o and blu_o are 0.
- R2: A data write at the first step only stores the byte in the holding register. No palette entry changes, chg_o stays 0, the colour outputs hold, and the pointer does not move.
- R3: A data write at the second step stores {data_i[6:0], held byte} (15 bits) into the entry at the pointer. Bit 7 of the second byte is discarded.
- R4: After a second-step data write the pointer increments by one, wrapping from 255 to 0, and the sequence returns to the first step.
- R5: An address write loads the pointer from addr_i and returns the sequence to the first step, so a byte held from an earlier first-step write is never committed.
- R6: In the cycle after a completing write, red_o shows entry bits 4:0, grn_o bits 9:5 and blu_o bits 14:10 of the value just stored. These outputs hold until the next completing write.
- R7: chg_o is 1 for exactly the cycle after a completing write whose new 15-bit value differs from the value previously stored at that entry. It is 0 in every other cycle.
- R8: rd_data_o shows the entry addressed by rd_addr_i at the previous clock edge. If a write to the same entry lands on that edge, the read returns the older value.
- R9: When addr_we_i and data_we_i are both high in a cycle, only the address write takes effect. The data byte is ignored and does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_we_i | input | 1 | Address port write strobe |
| addr_i | input | 8 | New entry pointer |
| data_we_i | input | 1 | Data port write strobe |
| data_i | input | 8 | Data byte |
| rd_addr_i | input | 8 | Renderer read address |
| rd_data_o | output | 15 | Renderer read data, one cycle after address |
| chg_o | output | 1 | Entry changed strobe |
| red_o | output | 5 | Red field of last completed entry |
| grn_o | output | 5 | Green field of last completed entry |
| blu_o | output | 5 | Blue field of last completed entry |

## Verification
If the byte-step flag ever inverts, the next completion writes the held byte into the upper field, or lands at a pointer one step off. That error appears on red_o, grn_o and blu_o one cycle after the faulty write, and on the read port as soon as the entry is addressed. A pointer that fails to wrap or increment shows up on the renderer read of the following entry. A compare against the wrong stored value shows as a missing or spurious chg_o pulse in the very next cycle. Random byte streams with mixed address writes are therefore checked every cycle, and a full palette sweep at the end catches anything misplaced.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned PAL_CH_W   = 5;
  localparam int unsigned PAL_NCH    = 3;
  localparam int unsigned PAL_BYTE_W = 8;
  localparam int unsigned PAL_ADDR_W = 8;
  localparam int unsigned PAL_ENT_W  = PAL_CH_W * PAL_NCH;

  // channel order inside an entry, low bits first
  typedef enum logic [1:0] {CH_RED = 2'd0, CH_GRN = 2'd1, CH_BLU = 2'd2} pal_ch_e;
endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ENT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              commit_o,
  output logic [ENT_W-1:0]  wr_data_o
);
  localparam int unsigned HI_W = ENT_W - BYTE_W;

  logic              phase_q;
  logic [BYTE_W-1:0] hold_q;
  logic [ADDR_W-1:0] addr_q;
  logic              do_data;

  assign do_data   = data_we_i & ~addr_we_i;
  assign commit_o  = do_data & phase_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = {data_i[HI_W-1:0], hold_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
      addr_q  <= '0;
    end else if (addr_we_i) begin
      addr_q  <= addr_i;
      phase_q <= 1'b0;
    end else if (do_data) begin
      phase_q <= ~phase_q;
      if (!phase_q) hold_q <= data_i;
      else          addr_q <= addr_q + 1'b1;
    end
  end

  // R2
  first_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_data && !phase_q) |=> ($stable(addr_q) && phase_q));
  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)) && !phase_q);
  // R5
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i |=> (addr_q == $past(addr_i)) && !phase_q);
  // R9
  addr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_i && data_we_i) |=> $stable(hold_q));
endmodule

// File: rtl/pal_mem.sv
module pal_mem #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ENT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ENT_W-1:0]  wdata_i,
  output logic [ENT_W-1:0]  cur_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ENT_W-1:0]  rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ENT_W-1:0] mem_q [DEPTH];

  assign cur_o = mem_q[waddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem_q[rd_addr_i];
  end

  // R3
  entry_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
  // R8
  rd_old_on_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rd_addr_i == waddr_i) |=> rd_data_o == $past(cur_o));
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage
  import pal_pkg::*;
#(
  parameter int unsigned CH_W  = 5,
  parameter int unsigned NCH   = 3,
  parameter int unsigned ENT_W = CH_W * NCH
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic [ENT_W-1:0]         new_i,
  input  logic [ENT_W-1:0]         old_i,
  output logic                     chg_o,
  output logic [NCH-1:0][CH_W-1:0] ch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_o <= 1'b0;
    else         chg_o <= commit_i && (new_i != old_i);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ch_o[c] <= '0;
      else if (commit_i) ch_o[c] <= new_i[c*CH_W +: CH_W];
    end
  end

  // R7
  chg_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> $past(commit_i));
  // R6
  rgb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ch_o));
  // R6
  rgb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> ch_o == $past(new_i));
endmodule

// File: rtl/pal_pair_writer.sv
module pal_pair_writer
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W = PAL_ADDR_W,
  parameter int unsigned BYTE_W = PAL_BYTE_W,
  parameter int unsigned CH_W   = PAL_CH_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        addr_we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        data_we_i,
  input  logic [BYTE_W-1:0]           data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [PAL_NCH*CH_W-1:0]     rd_data_o,
  output logic                        chg_o,
  output logic [CH_W-1:0]             red_o,
  output logic [CH_W-1:0]             grn_o,
  output logic [CH_W-1:0]             blu_o
);
  localparam int unsigned ENT_W = PAL_NCH * CH_W;

  logic [ADDR_W-1:0]               wr_addr;
  logic                            commit;
  logic [ENT_W-1:0]                wr_data;
  logic [ENT_W-1:0]                cur_data;
  logic [PAL_NCH-1:0][CH_W-1:0]    ch;

  pal_wr_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ENT_W(ENT_W)) u_seq (
    .clk_i, .rst_ni, .addr_we_i, .addr_i, .data_we_i, .data_i,
    .wr_addr_o(wr_addr), .commit_o(commit), .wr_data_o(wr_data)
  );

  pal_mem #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_mem (
    .clk_i, .rst_ni, .we_i(commit), .waddr_i(wr_addr), .wdata_i(wr_data),
    .cur_o(cur_data), .rd_addr_i, .rd_data_o
  );

  pal_out_stage #(.CH_W(CH_W), .NCH(PAL_NCH), .ENT_W(ENT_W)) u_out (
    .clk_i, .rst_ni, .commit_i(commit), .new_i(wr_data), .old_i(cur_data),
    .chg_o, .ch_o(ch)
  );

  assign red_o = ch[CH_RED];
  assign grn_o = ch[CH_GRN];
  assign blu_o = ch[CH_BLU];

  // R7
  chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o && !commit) |=> !chg_o);
  // R1
  reset_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !chg_o && red_o == '0 && grn_o == '0 && blu_o == '0);
endmodule

// File: tb/tb_pal_pair_writer.sv
module tb_pal_pair_writer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_we = 1'b0, data_we = 1'b0;
  logic [7:0]  addr = '0, data = '0, rd_addr = '0;
  logic [14:0] rd_data;
  logic        chg;
  logic [4:0]  red, grn, blu;

  always #10 clk = ~clk;

  pal_pair_writer dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_we_i(addr_we), .addr_i(addr),
    .data_we_i(data_we), .data_i(data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .chg_o(chg), .red_o(red), .grn_o(grn), .blu_o(blu)
  );

  int errs = 0, checks = 0;
  logic [14:0] m_mem [256];
  logic [7:0]  m_addr, m_hold;
  logic        m_phase, m_chg;
  logic [14:0] m_rgb;

  function automatic logic [14:0] join_bytes(logic [7:0] hi, logic [7:0] lo);
    return {hi[6:0], lo};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; called at a falling edge, returns at the next one
  task automatic op(bit aw, logic [7:0] a, bit dw, logic [7:0] d, logic [7:0] ra);
    logic [14:0] exp_rd, nv;
    exp_rd = m_mem[ra];
    m_chg = 1'b0;
    if (aw) begin
      m_addr = a; m_phase = 1'b0;
    end else if (dw) begin
      if (!m_phase) begin
        m_hold = d; m_phase = 1'b1;
      end else begin
        nv = join_bytes(d, m_hold);
        m_chg = (nv != m_mem[m_addr]);
        m_mem[m_addr] = nv;
        m_rgb = nv;
        m_addr = m_addr + 8'd1;
        m_phase = 1'b0;
      end
    end
    addr_we = aw; addr = a; data_we = dw; data = d; rd_addr = ra;
    @(posedge clk);
    @(negedge clk);
    addr_we = 1'b0; data_we = 1'b0;
    chk("R7 chg", chg, m_chg);
    chk("R6 rgb", {blu, grn, red}, m_rgb);
    chk("R8 rd", rd_data, exp_rd);
  endtask

  task automatic wr_addr(logic [7:0] a); op(1, a, 0, 8'h00, a); endtask
  task automatic wr_data(logic [7:0] d); op(0, 8'h00, 1, d, m_addr); endtask
  task automatic rd(logic [7:0] a);      op(0, 8'h00, 0, 8'h00, a); endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h00c0_10a5));
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_addr = '0; m_hold = '0; m_phase = 1'b0; m_chg = 1'b0; m_rgb = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 chg", chg, 0);
    chk("R1 rgb", {blu, grn, red}, 0);
    rst_ni = 1'b1;
    rd(8'd0);
    chk("R1 rd0", rd_data, 0);
    rd(8'd255);
    chk("R1 rd255", rd_data, 0);

    // R2/R3: first byte held only, second completes with bit 7 dropped
    wr_addr(8'd10);
    wr_data(8'h34);
    chk("R2 chg", chg, 0);
    chk("R2 rgb", {blu, grn, red}, 0);
    rd(8'd10);
    chk("R2 entry", rd_data, 0);
    wr_data(8'hD2);
    chk("R3 chg", chg, 1);
    rd(8'd10);
    chk("R3 entry", rd_data, 15'h5234);
    chk("R6 fields", {blu, grn, red}, {5'h14, 5'h11, 5'h14});
    // R7: same value again (top bit differs only) gives no strobe
    wr_addr(8'd10);
    wr_data(8'h34);
    wr_data(8'h52);
    chk("R7 same", chg, 0);

    // R4: wrap 255 -> 0
    wr_addr(8'd255);
    wr_data(8'h11); wr_data(8'h22);
    wr_data(8'h33); wr_data(8'h44);
    rd(8'd255);
    chk("R4 e255", rd_data, 15'h2211);
    rd(8'd0);
    chk("R4 e0", rd_data, 15'h4433);

    // R5: address write discards pending first byte
    wr_addr(8'd20);
    wr_data(8'hAA);
    wr_addr(8'd20);
    wr_data(8'h01); wr_data(8'h02);
    rd(8'd20);
    chk("R5 entry", rd_data, 15'h0201);

    // R9: both strobes together, data ignored
    op(1, 8'd30, 1, 8'h77, 8'd30);
    wr_data(8'h05); wr_data(8'h06);
    rd(8'd30);
    chk("R9 entry", rd_data, 15'h0605);
    rd(8'd31);
    chk("R9 next", rd_data, 0);

    // R8: read of an entry written on the same edge gives the old value
    wr_addr(8'd40);
    wr_data(8'h99);
    op(0, 8'h00, 1, 8'h0F, 8'd40);
    rd(8'd40);
    chk("R8 new", rd_data, 15'h0F99);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 8)       op(1, 8'($urandom), 0, 8'h00, 8'($urandom));
      else if (r < 12) op(1, 8'($urandom), 1, 8'($urandom), 8'($urandom));
      else if (r < 92) op(0, 8'h00, 1, 8'($urandom), 8'($urandom));
      else             op(0, 8'h00, 0, 8'h00, 8'($urandom));
    end

    // R3 full sweep
    for (int i = 0; i < 256; i++) begin
      rd(8'(i));
      chk("R3 sweep", rd_data, m_mem[i]);
    end
    summary();
  end
endmodule